// File: doc/BRIEF.md
# Binary Trie Longest-Prefix Lookup Engine

This block finds the longest stored prefix that matches a destination address. It walks a binary trie held in a small on-chip node table. Each table entry has a zero-branch child index, a one-branch child index and an optional next-hop value. Starting from the root entry, the engine uses the address bits from the most significant bit downward, one bit per clock. It keeps the next hop of the deepest visited entry that carries one. The cost of a lookup depends on the address width, not on how many prefixes are stored.

Software builds the trie through a node write port. Construction, compression and update policy are handled outside the block. Lookups use a valid/ready request channel and a valid/ready response channel. Each response carries a hit flag, the next hop and the number of table entries visited.

The controller is a three-state machine:
- `WK_IDLE` waits for a request. The ACCEPT transition goes to `WK_STEP` when `req_valid` is high.
- `WK_STEP` visits one entry per cycle. The DESCEND transition stays in `WK_STEP` and moves to the chosen child. The FINISH transition goes to `WK_DONE` when that child index is zero or the last address bit has been used.
- `WK_DONE` presents the response. The DELIVER transition goes back to `WK_IDLE` when `rsp_ready` is high.

Top module: `trie_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every table entry reads as child indices 0 with no next hop.
- R2: A write with `wr_en` high replaces the whole entry at `wr_idx` (both child indices, hop-present flag and hop value). Later lookups use the new contents.
- R3: Address bits are taken from bit ADDR_W-1 downward. A 0 bit follows the zero-branch child index and a 1 bit follows the one-branch child index. Entry 0 is the root.
- R4: The response reports the next hop of the deepest visited entry that has its hop-present flag set. A shallower hop is kept while the walk continues below it.
- R5: A child index of 0 means no child. The walk ends at the entry whose selected child is 0.
- R6: After ADDR_W bits have been used, the entry reached is still visited and the walk ends. The step count is then ADDR_W+1, which is its maximum.
- R7: When no visited entry carries a next hop, the response has `rsp_hit`=0 and `rsp_hop`=0, even if an earlier lookup hit.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response fields hold steady and `req_ready` stays 0. Requests offered during a walk or while a response is pending are ignored.
- R9: `rsp_steps` equals the number of table entries visited, counting the root. It is between 1 and ADDR_W+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle |
| req_addr | input | ADDR_W | Address to resolve |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | A matching prefix was found |
| rsp_hop | output | HOP_W | Next hop of the longest match, 0 on a miss |
| rsp_steps | output | STEP_W | Table entries visited |
| wr_en | input | 1 | Table entry write strobe |
| wr_idx | input | PTR_W | Entry written |
| wr_left | input | PTR_W | Zero-branch child index (0 = none) |
| wr_right | input | PTR_W | One-branch child index (0 = none) |
| wr_hop_vld | input | 1 | Entry ends a prefix |
| wr_hop | input | HOP_W | Next hop stored with the entry |

## Verification
The assertions check on every cycle:
- a miss never carries a hop value;
- the reported step count stays within 1 to ADDR_W+1;
- a pending response holds steady;
- the request and response sides are never active together;
- the walk ends after a null child or after the last bit;
- the match flag is cleared only when a new lookup starts.

Only the bench scenarios can show that the right branch was taken and that the deepest hop was returned. They compare each result with an independent scan of a prefix list. The scenarios cover an empty table, nested prefixes, a full-width chain, a default route, an entry rewrite and a request offered while the engine is busy.

// File: rtl/trie_pkg.sv
package trie_pkg;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_STEP = 2'd1,
        WK_DONE = 2'd2
    } walk_state_t;

endpackage

// File: rtl/trie_node_mem.sv
module trie_node_mem #(
    parameter int NODES = 64,
    parameter int HOP_W = 8,
    localparam int PTR_W = $clog2(NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [PTR_W-1:0] wr_left,
    input  logic [PTR_W-1:0] wr_right,
    input  logic             wr_hop_vld,
    input  logic [HOP_W-1:0] wr_hop,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [PTR_W-1:0] rd_left,
    output logic [PTR_W-1:0] rd_right,
    output logic             rd_hop_vld,
    output logic [HOP_W-1:0] rd_hop
);

    logic [PTR_W-1:0] left_q  [NODES];
    logic [PTR_W-1:0] right_q [NODES];
    logic             hv_q    [NODES];
    logic [HOP_W-1:0] hop_q   [NODES];

    for (genvar g = 0; g < NODES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                left_q[g]  <= '0;
                right_q[g] <= '0;
                hv_q[g]    <= 1'b0;
                hop_q[g]   <= '0;
            end else if (wr_en && (wr_idx == PTR_W'(g))) begin
                left_q[g]  <= wr_left;
                right_q[g] <= wr_right;
                hv_q[g]    <= wr_hop_vld;
                hop_q[g]   <= wr_hop;
            end
        end
    end

    always_comb begin
        rd_left    = left_q[rd_idx];
        rd_right   = right_q[rd_idx];
        rd_hop_vld = hv_q[rd_idx];
        rd_hop     = hop_q[rd_idx];
    end

    // R2: a written entry is visible on the read side one cycle later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_idx == wr_idx) |=> (rd_idx != $past(wr_idx)) ||
            (rd_left == $past(wr_left) && rd_right == $past(wr_right) &&
             rd_hop_vld == $past(wr_hop_vld)));

endmodule

// File: rtl/trie_hop_tracker.sv
module trie_hop_tracker #(
    parameter int HOP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             visit,
    input  logic             node_hop_vld,
    input  logic [HOP_W-1:0] node_hop,
    output logic             best_vld,
    output logic [HOP_W-1:0] best_hop
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_vld <= 1'b0;
            best_hop <= '0;
        end else if (clr) begin
            best_vld <= 1'b0;
            best_hop <= '0;
        end else if (visit && node_hop_vld) begin
            best_vld <= 1'b1;
            best_hop <= node_hop;
        end
    end

    // R4: a found match is only forgotten when a new lookup starts
    a_r4_keep_match: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(best_vld) |-> $past(clr));

    // R7: without a match the hop register is empty
    a_r7_empty_hop: assert property (@(posedge clk) disable iff (!rst_n)
        !best_vld |-> best_hop == '0);

endmodule

// File: rtl/trie_walk_ctrl.sv
module trie_walk_ctrl
    import trie_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 6,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [STEP_W-1:0] rsp_steps,
    input  logic [PTR_W-1:0]  node_left,
    input  logic [PTR_W-1:0]  node_right,
    output logic [PTR_W-1:0]  node_idx,
    output logic              track_clr,
    output logic              track_visit
);

    localparam int DEPTH_W = $clog2(ADDR_W + 1);
    localparam logic [DEPTH_W-1:0] LAST_DEPTH = DEPTH_W'(ADDR_W);

    walk_state_t       state, state_nxt;
    logic [ADDR_W-1:0] addr_sh;
    logic [PTR_W-1:0]  cur;
    logic [DEPTH_W-1:0] depth;
    logic [STEP_W-1:0] steps;

    logic              cur_bit;
    logic [PTR_W-1:0]  child;
    logic              at_last;
    logic              stop;

    assign cur_bit = addr_sh[ADDR_W-1];
    assign child   = cur_bit ? node_right : node_left;
    assign at_last = (depth == LAST_DEPTH);
    assign stop    = at_last || (child == '0);

    always_comb begin
        state_nxt = state;
        unique case (state)
            WK_IDLE: if (req_valid) state_nxt = WK_STEP;      // ACCEPT
            WK_STEP: if (stop)      state_nxt = WK_DONE;      // FINISH / DESCEND
            WK_DONE: if (rsp_ready) state_nxt = WK_IDLE;      // DELIVER
            default:                state_nxt = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WK_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_sh <= '0;
            cur     <= '0;
            depth   <= '0;
            steps   <= '0;
        end else begin
            unique case (state)
                WK_IDLE: if (req_valid) begin
                    addr_sh <= req_addr;
                    cur     <= '0;
                    depth   <= '0;
                    steps   <= '0;
                end
                WK_STEP: begin
                    steps <= steps + 1'b1;
                    if (!stop) begin
                        cur     <= child;
                        addr_sh <= addr_sh << 1;
                        depth   <= depth + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready   = (state == WK_IDLE);
        rsp_valid   = (state == WK_DONE);
        rsp_steps   = steps;
        node_idx    = cur;
        track_clr   = (state == WK_IDLE) && req_valid;
        track_visit = (state == WK_STEP);
    end

    // R5: a missing child ends the walk
    a_r5_null_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WK_STEP && child == '0) |=> state == WK_DONE);

    // R6: the walk never runs past the last address bit
    a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WK_STEP && at_last) |=> state == WK_DONE);

    // R8: a pending response holds until taken
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WK_DONE && !rsp_ready) |=> (state == WK_DONE && $stable(steps)));

endmodule

// File: rtl/trie_walker.sv
module trie_walker #(
    parameter int ADDR_W = 32,
    parameter int NODES  = 64,
    parameter int HOP_W  = 8,
    localparam int PTR_W  = $clog2(NODES),
    localparam int STEP_W = $clog2(ADDR_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_hit,
    output logic [HOP_W-1:0]  rsp_hop,
    output logic [STEP_W-1:0] rsp_steps,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [PTR_W-1:0]  wr_left,
    input  logic [PTR_W-1:0]  wr_right,
    input  logic              wr_hop_vld,
    input  logic [HOP_W-1:0]  wr_hop
);

    logic [PTR_W-1:0] node_idx, node_left, node_right;
    logic             node_hop_vld;
    logic [HOP_W-1:0] node_hop;
    logic             track_clr, track_visit;
    logic             best_vld;
    logic [HOP_W-1:0] best_hop;

    trie_node_mem #(.NODES(NODES), .HOP_W(HOP_W)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_left    (wr_left),
        .wr_right   (wr_right),
        .wr_hop_vld (wr_hop_vld),
        .wr_hop     (wr_hop),
        .rd_idx     (node_idx),
        .rd_left    (node_left),
        .rd_right   (node_right),
        .rd_hop_vld (node_hop_vld),
        .rd_hop     (node_hop)
    );

    trie_walk_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .STEP_W(STEP_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_ready   (req_ready),
        .rsp_ready   (rsp_ready),
        .rsp_valid   (rsp_valid),
        .rsp_steps   (rsp_steps),
        .node_left   (node_left),
        .node_right  (node_right),
        .node_idx    (node_idx),
        .track_clr   (track_clr),
        .track_visit (track_visit)
    );

    trie_hop_tracker #(.HOP_W(HOP_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (track_clr),
        .visit        (track_visit),
        .node_hop_vld (node_hop_vld),
        .node_hop     (node_hop),
        .best_vld     (best_vld),
        .best_hop     (best_hop)
    );

    assign rsp_hit = best_vld;
    assign rsp_hop = best_hop;

    // R7: a miss carries no hop value
    a_r7_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_hop == '0);

    // R9: step count range on every response
    a_r9_steps_range: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_steps >= STEP_W'(1) && rsp_steps <= STEP_W'(ADDR_W + 1)));

    // R8: request and response sides are never active together
    a_r8_sides_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, rsp_valid}));

endmodule

// File: tb/trie_walker_tb.sv
module trie_walker_tb;

    localparam int W = 32;
    localparam int N = 64;
    localparam int HW = 8;
    localparam int PW = $clog2(N);
    localparam int SW = $clog2(W + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [W-1:0] req_addr = '0;
    logic rsp_valid, rsp_ready = 1'b0, rsp_hit;
    logic [HW-1:0] rsp_hop;
    logic [SW-1:0] rsp_steps;
    logic wr_en = 1'b0, wr_hop_vld = 1'b0;
    logic [PW-1:0] wr_idx = '0, wr_left = '0, wr_right = '0;
    logic [HW-1:0] wr_hop = '0;

    always #4 clk = ~clk;

    trie_walker #(.ADDR_W(W), .NODES(N), .HOP_W(HW)) u_dut (.*);

    int total = 0, bad = 0;
    int cycles = 0;

    // bench shadow of the trie it builds, and the prefix list reference
    int sh_l [N], sh_r [N], sh_hv [N], sh_hop [N];
    int nxt_free = 1;
    logic [63:0] pv [16];
    int pl [16], ph [16], pn [16];
    int np = 0;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_node(int idx);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = PW'(idx);
        wr_left = PW'(sh_l[idx]); wr_right = PW'(sh_r[idx]);
        wr_hop_vld = sh_hv[idx][0]; wr_hop = HW'(sh_hop[idx]);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic insert(logic [63:0] val, int len, int hop);
        int cur = 0;
        for (int i = 0; i < len; i++) begin
            int b = int'((val >> (len - 1 - i)) & 64'd1);
            int c = b ? sh_r[cur] : sh_l[cur];
            if (c == 0) begin
                c = nxt_free++;
                if (b) sh_r[cur] = c; else sh_l[cur] = c;
                write_node(cur);
            end
            cur = c;
        end
        sh_hv[cur] = 1; sh_hop[cur] = hop;
        write_node(cur);
        pv[np] = val; pl[np] = len; ph[np] = hop; pn[np] = cur; np++;
    endtask

    function automatic int ref_steps(logic [W-1:0] a);
        int best = 0;
        logic [63:0] a64 = {32'd0, a};
        for (int L = 1; L <= W; L++)
            for (int i = 0; i < np; i++)
                if (pl[i] >= L && (pv[i] >> (pl[i] - L)) == (a64 >> (W - L))) best = L;
        return best + 1;
    endfunction

    task automatic ref_match(logic [W-1:0] a, output logic hit, output int hop);
        int bl = -1;
        logic [63:0] a64 = {32'd0, a};
        hit = 1'b0; hop = 0;
        for (int i = 0; i < np; i++)
            if (pl[i] > bl && (pl[i] == 0 || (a64 >> (W - pl[i])) == pv[i])) begin
                bl = pl[i]; hit = 1'b1; hop = ph[i];
            end
    endtask

    task automatic wait_rsp();
        int n = 0;
        while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic send(logic [W-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic take();
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic lookup_check(logic [W-1:0] a, string req);
        logic eh; int ehop;
        ref_match(a, eh, ehop);
        send(a);
        wait_rsp();
        check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({req, " hit"}, 64'(rsp_hit), 64'(eh));
        check({req, " hop"}, 64'(rsp_hop), 64'(ehop));
        check({req, " R9 steps"}, 64'(rsp_steps), 64'(ref_steps(a)));
        take();
    endtask

    task automatic t_reset();
        check("R1 req_ready", 64'(req_ready), 64'd1);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_empty();
        lookup_check(32'h8000_0001, "R1 R5 R7 empty");
    endtask

    task automatic t_nested();
        insert(64'b10, 2, 'hA1);
        insert(64'b10110, 5, 'hB2);
        insert(64'b011, 3, 'hC3);
        lookup_check(32'hB000_0000, "R3 R4 deep");
        lookup_check(32'hA000_0000, "R4 R5 shallow kept");
        lookup_check(32'h6000_0000, "R3 zero branch");
        lookup_check(32'h4000_0000, "R7 no stale hop");
        lookup_check(32'hFF00_0000, "R5 R7 short miss");
    endtask

    task automatic t_full_width();
        insert(64'hDEAD, 16, 'h16);
        insert(64'hDEAD_BEEF, 32, 'h5E);
        lookup_check(32'hDEAD_BEEF, "R6 full width");
        check("R6 max steps", 64'(ref_steps(32'hDEAD_BEEF)), 64'd33);
        lookup_check(32'hDEAD_BEEE, "R4 R5 last bit differs");
        lookup_check(32'hDEAD_0000, "R4 mid prefix");
    endtask

    task automatic t_default();
        insert(64'd0, 0, 'h77);
        lookup_check(32'hFF00_0000, "R4 default route");
        lookup_check(32'h4000_0000, "R4 default over miss");
    endtask

    task automatic t_rewrite();
        for (int i = 0; i < np; i++)
            if (pl[i] == 5) begin
                ph[i] = 'hBB; sh_hop[pn[i]] = 'hBB;
                write_node(pn[i]);
            end
        lookup_check(32'hB000_0000, "R2 rewrite");
    endtask

    task automatic t_busy();
        logic eh; int ehop;
        ref_match(32'hDEAD_BEEF, eh, ehop);
        send(32'hDEAD_BEEF);
        @(negedge clk);
        check("R8 ready low while walking", 64'(req_ready), 64'd0);
        req_valid = 1'b1; req_addr = 32'h6000_0000;
        wait_rsp();
        for (int k = 0; k < 3; k++) @(negedge clk);
        check("R8 held valid", 64'(rsp_valid), 64'd1);
        check("R8 ready low while pending", 64'(req_ready), 64'd0);
        check("R8 held hop", 64'(rsp_hop), 64'(ehop));
        check("R8 held steps", 64'(rsp_steps), 64'd33);
        req_valid = 1'b0;
        take();
        check("R8 back to idle", 64'(req_ready), 64'd1);
        check("R8 no extra response", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            sh_l[i] = 0; sh_r[i] = 0; sh_hv[i] = 0; sh_hop[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_nested();
        t_full_width();
        t_default();
        t_rewrite();
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule